// File: doc/BRIEF.md
# CRC-16 Word Folding Engine

This block computes a non-reflected 16-bit CRC using the generator polynomial 0x1021. The remainder starts at 0xFFFF and no final inversion is applied. Each clock it can absorb up to one 32-bit data word. Four byte-lane enables select how many bytes of that word take part. A DMA engine can therefore stream whole words, and a processor can then write the last one to three bytes of a message whose length is not a multiple of four.

The enabled bytes pass through a chain of unrolled shift-and-XOR networks, one per lane, so the selected bytes are absorbed in a single clock. A second, bit-serial input absorbs one message bit per clock into the same remainder. It serves as a reference path: it must agree with the byte and word paths for any byte sequence. A clear input restarts the computation. The registered CRC output can be read at any time.

Top module: `crc16_word_engine`

## Requirements
- R1: A synchronous active-high reset sets `crc_o` to 0xFFFF and `err_o` to 0.
- R2: The CRC is 16 bits wide, with polynomial 0x1021, no bit reflection and a final XOR of 0x0000. The ASCII message "123456789" gives 0x29B1 whichever legal mix of writes delivers it.
- R3: A write with `wr_be` = 4'b1111 absorbs all four bytes in one clock. The order is lane 3 (`wr_data[31:24]`) first, then lane 2, lane 1 and lane 0, and each byte is taken MSB first.
- R4: A write with `wr_be` = 4'b1110, 4'b1100 or 4'b1000 absorbs the top three, two or one byte(s) in that same order. The data on disabled lanes has no effect.
- R5: A write with any other `wr_be` value, 4'b0000 included, leaves the CRC unchanged. It raises `err_o` for exactly the one cycle after it.
- R6: `clr` reloads 0xFFFF and drives `err_o` low. It takes priority over a word write or a serial bit in the same cycle.
- R7: When `bit_vld` is high and no write or clear is present, `bit_din` is absorbed as the next message bit. Eight serial bits give the same CRC as one single-byte write of those bits, MSB first.
- R8: When a legal word write and a serial bit arrive in the same cycle, only the word is absorbed and the bit is dropped.
- R9: `crc_o` is registered. It reflects every input accepted up to the previous clock edge, and it holds its value in cycles with no clear, write or bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Restart the CRC at its initial value |
| wr_en | input | 1 | Word write strobe |
| wr_be | input | 4 | Byte-lane enables, lane 3 is the most significant |
| wr_data | input | 32 | Data word |
| bit_vld | input | 1 | Serial bit strobe |
| bit_din | input | 1 | Serial message bit |
| crc_o | output | 16 | Current CRC value |
| err_o | output | 1 | One-cycle flag for a rejected enable pattern |

## Verification
The bench delivers the same check string three ways: as aligned words with a one-byte tail, as a three-byte head followed by a two-byte tail, and as 72 serial bits. A design with a wrong lane order or a wrong tail selection would give a value other than 0x29B1 on at least one of these deliveries. Non-contiguous, low-aligned and empty enable patterns are sent to confirm that the remainder does not move and that the error flag lasts exactly one cycle. A decoder that accepted holes in the enable pattern, or a sticky flag, would be caught here. The bench also collides clear with writes, and collides writes with serial bits. A wrong priority would show up as a corrupted restart value or as a bit counted twice.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

  localparam int          CRC16_W      = 16;
  localparam logic [15:0] CRC16_POLY   = 16'h1021;
  localparam logic [15:0] CRC16_SEED   = 16'hFFFF;
  localparam logic [15:0] CRC16_XOROUT = 16'h0000;

  // Source selected for the next remainder value
  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_CLEAR,
    SRC_WORD,
    SRC_BIT,
    SRC_REJECT
  } crc_src_e;

endpackage

// File: rtl/crc16_fold.sv
// Unrolled MSB-first shift/XOR network: absorbs DIN_W message bits.
module crc16_fold #(
  parameter int                 CRC_W = 16,
  parameter logic [CRC_W-1:0]   POLY  = 16'h1021,
  parameter int                 DIN_W = 8
) (
  input  logic [CRC_W-1:0] crc_in,
  input  logic [DIN_W-1:0] din,
  output logic [CRC_W-1:0] crc_out
);

  logic [CRC_W-1:0] acc;
  logic             fb;

  always_comb begin
    acc = crc_in;
    fb  = 1'b0;
    for (int i = DIN_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ din[i];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ POLY;
    end
    crc_out = acc;
  end

endmodule

// File: rtl/crc16_be_decode.sv
// Accepts only enable patterns that are contiguous from the top lane.
module crc16_be_decode #(
  parameter int LANES = 4,
  parameter int CNT_W = 3
) (
  input  logic [LANES-1:0] be,
  output logic             ok,
  output logic [CNT_W-1:0] cnt
);

  int               lead;
  logic             run;
  logic [LANES-1:0] want;

  always_comb begin
    lead = 0;
    run  = 1'b1;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (run && be[i]) lead = lead + 1;
      else              run  = 1'b0;
    end
    for (int i = 0; i < LANES; i++) begin
      want[i] = ((LANES - 1 - i) < lead);
    end
    ok  = (lead > 0) && (be == want);
    cnt = CNT_W'(lead);
  end

endmodule

// File: rtl/crc16_lane_chain.sv
// Chains one byte fold per lane, top lane first, and taps after cnt lanes.
module crc16_lane_chain #(
  parameter int               CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY   = 16'h1021,
  parameter int               LANES  = 4,
  parameter int               BYTE_W = 8,
  parameter int               CNT_W  = 3
) (
  input  logic [CRC_W-1:0]        crc_in,
  input  logic [LANES*BYTE_W-1:0] data,
  input  logic [CNT_W-1:0]        cnt,
  output logic [CRC_W-1:0]        crc_out
);

  logic [CRC_W-1:0] stage [LANES+1];

  assign stage[0] = crc_in;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    crc16_fold #(
      .CRC_W (CRC_W),
      .POLY  (POLY),
      .DIN_W (BYTE_W)
    ) u_fold (
      .crc_in  (stage[k]),
      .din     (data[(LANES-1-k)*BYTE_W +: BYTE_W]),
      .crc_out (stage[k+1])
    );
  end

  always_comb begin
    crc_out = stage[0];
    for (int k = 1; k <= LANES; k++) begin
      if (int'(cnt) == k) crc_out = stage[k];
    end
  end

endmodule

// File: rtl/crc16_word_engine.sv
module crc16_word_engine
  import crc16_pkg::*;
#(
  parameter int                 CRC_W  = CRC16_W,
  parameter logic [CRC_W-1:0]   POLY   = CRC16_POLY,
  parameter logic [CRC_W-1:0]   SEED   = CRC16_SEED,
  parameter logic [CRC_W-1:0]   XOROUT = CRC16_XOROUT,
  parameter int                 LANES  = 4,
  parameter int                 BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        wr_be,
  input  logic [LANES*BYTE_W-1:0] wr_data,
  input  logic                    bit_vld,
  input  logic                    bit_din,
  output logic [CRC_W-1:0]        crc_o,
  output logic                    err_o
);

  localparam int CNT_W = $clog2(LANES + 1);

  logic [CRC_W-1:0] crc_q;
  logic             err_q;
  logic             be_ok;
  logic [CNT_W-1:0] be_cnt;
  logic [CRC_W-1:0] word_crc;
  logic [CRC_W-1:0] bit_crc;
  crc_src_e         src;

  crc16_be_decode #(
    .LANES (LANES),
    .CNT_W (CNT_W)
  ) u_decode (
    .be  (wr_be),
    .ok  (be_ok),
    .cnt (be_cnt)
  );

  crc16_lane_chain #(
    .CRC_W  (CRC_W),
    .POLY   (POLY),
    .LANES  (LANES),
    .BYTE_W (BYTE_W),
    .CNT_W  (CNT_W)
  ) u_chain (
    .crc_in  (crc_q),
    .data    (wr_data),
    .cnt     (be_cnt),
    .crc_out (word_crc)
  );

  crc16_fold #(
    .CRC_W (CRC_W),
    .POLY  (POLY),
    .DIN_W (1)
  ) u_serial (
    .crc_in  (crc_q),
    .din     (bit_din),
    .crc_out (bit_crc)
  );

  // Priority: clear, then word write, then serial bit
  always_comb begin
    if (clr)          src = SRC_CLEAR;
    else if (wr_en)   src = be_ok ? SRC_WORD : SRC_REJECT;
    else if (bit_vld) src = SRC_BIT;
    else              src = SRC_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= SEED;
      err_q <= 1'b0;
    end else begin
      case (src)
        SRC_CLEAR: crc_q <= SEED;
        SRC_WORD:  crc_q <= word_crc;
        SRC_BIT:   crc_q <= bit_crc;
        default:   crc_q <= crc_q;
      endcase
      err_q <= (src == SRC_REJECT);
    end
  end

  assign crc_o = crc_q ^ XOROUT;
  assign err_o = err_q;

  // R1
  rst_init_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (crc_q == SEED) && !err_q);

  // R6
  clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (crc_q == SEED) && !err_q);

  // R5
  bad_be_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !clr && !be_ok) |-> (crc_q == $past(crc_q)) && err_q);

  // R8
  word_over_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !clr && be_ok && bit_vld) |-> crc_q == $past(word_crc));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!clr && !wr_en && !bit_vld) |-> $stable(crc_q) && !err_q);

endmodule

// File: tb/test_crc16_word_engine.sv
`timescale 1ns/1ps
module test_crc16_word_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = 4'h0;
  logic [31:0] wr_data = 32'h0;
  logic        bit_vld = 1'b0;
  logic        bit_din = 1'b0;
  logic [15:0] crc_o;
  logic        err_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  crc16_word_engine i_crc16_word_engine (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .wr_en   (wr_en),
    .wr_be   (wr_be),
    .wr_data (wr_data),
    .bit_vld (bit_vld),
    .bit_din (bit_din),
    .crc_o   (crc_o),
    .err_o   (err_o)
  );

  // {clear_first, be, data}
  localparam int NV = 12;
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 4'hF, 32'h31323334},
    {1'b0, 4'hF, 32'h35363738},
    {1'b0, 4'h8, 32'h39AABBCC},
    {1'b1, 4'hE, 32'h313233EE},
    {1'b0, 4'hF, 32'h34353637},
    {1'b0, 4'hC, 32'h38391122},
    {1'b1, 4'h8, 32'h00FFFFFF},
    {1'b0, 4'hF, 32'hDEADBEEF},
    {1'b0, 4'hC, 32'hFFFF0000},
    {1'b0, 4'hE, 32'h12345678},
    {1'b1, 4'hF, 32'h00000000},
    {1'b0, 4'hF, 32'hFFFFFFFF}
  };

  localparam logic [71:0] CHECK_STR = 72'h313233343536373839;

  function automatic logic [15:0] ref_byte(logic [15:0] c, logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic do_write(logic [3:0] be, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_be = 4'h0;
  endtask

  task automatic send_bits(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); bit_vld = 1'b1; bit_din = b[i];
    end
    @(negedge clk); bit_vld = 1'b0;
  endtask

  initial begin
    logic [15:0] exp;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 crc", crc_o, 16'hFFFF);
    check("R1 err", {15'h0, err_o}, 16'h0);

    // Vector table: R2 R3 R4
    exp = 16'hFFFF;
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][36]) begin
        do_clear();
        exp = 16'hFFFF;
      end
      do_write(VEC[v][35:32], VEC[v][31:0]);
      for (int ln = 3; ln >= 0; ln--) begin
        if (VEC[v][32+ln]) exp = ref_byte(exp, VEC[v][ln*8 +: 8]);
      end
      check(VEC[v][35:32] == 4'hF ? "R3 word" : "R4 partial", crc_o, exp);
      if (v == 2 || v == 5) check("R2 check string", crc_o, 16'h29B1);
    end

    // R4 disabled lanes ignored
    do_clear();
    do_write(4'h8, 32'h31000000);
    held = crc_o;
    do_clear();
    do_write(4'h8, 32'h31FFFFFF);
    check("R4 lane data ignored", crc_o, held);

    // R2 one byte per write
    do_clear();
    for (int k = 8; k >= 0; k--) do_write(4'h8, {CHECK_STR[k*8 +: 8], 24'h0});
    check("R2 bytewise", crc_o, 16'h29B1);

    // R5 illegal patterns
    begin
      logic [3:0] bad [5] = '{4'h0, 4'h1, 4'h5, 4'h7, 4'hB};
      for (int j = 0; j < 5; j++) begin
        held = crc_o;
        do_write(bad[j], 32'h12345678);
        check("R5 crc unchanged", crc_o, held);
        check("R5 err raised", {15'h0, err_o}, 16'h1);
      end
      @(negedge clk);
      check("R5 err one cycle", {15'h0, err_o}, 16'h0);
    end

    // R9 idle hold
    held = crc_o;
    repeat (5) @(negedge clk);
    check("R9 idle hold", crc_o, held);

    // R6 clear beats write
    @(negedge clk); clr = 1'b1; wr_en = 1'b1; wr_be = 4'hF; wr_data = 32'hCAFEF00D;
    @(negedge clk); clr = 1'b0; wr_en = 1'b0;
    check("R6 clr over write", crc_o, 16'hFFFF);
    // R6 clear beats bad write and serial bit
    do_write(4'hF, 32'h01020304);
    @(negedge clk); clr = 1'b1; wr_en = 1'b1; wr_be = 4'h3; bit_vld = 1'b1; bit_din = 1'b1;
    @(negedge clk); clr = 1'b0; wr_en = 1'b0; bit_vld = 1'b0;
    check("R6 clr crc", crc_o, 16'hFFFF);
    check("R6 clr err", {15'h0, err_o}, 16'h0);

    // R7 serial path
    do_clear();
    send_bits(8'h31);
    check("R7 eight bits", crc_o, ref_byte(16'hFFFF, 8'h31));
    for (int k = 7; k >= 0; k--) send_bits(CHECK_STR[k*8 +: 8]);
    check("R7 serial check string", crc_o, 16'h29B1);

    // R8 word over serial bit
    do_clear();
    @(negedge clk); wr_en = 1'b1; wr_be = 4'h8; wr_data = 32'h31000000;
    bit_vld = 1'b1; bit_din = 1'b1;
    @(negedge clk); wr_en = 1'b0; bit_vld = 1'b0;
    check("R8 bit dropped", crc_o, ref_byte(16'hFFFF, 8'h31));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule